// File: doc/BRIEF.md
# APB Interrupt Injection Override

This block sits in the path between a set of peripheral interrupt sources and the shared peripheral inputs of an interrupt controller. For every one of 160 interrupt lines, software can replace the live hardware level with a level of its own choosing. This lets test firmware or a debug agent raise any shared interrupt without the peripheral that normally drives it.

Software reaches two register banks through an APB slave port. The first bank holds the software-chosen levels. The second bank holds, for each line, a select bit. A set select bit routes the stored software level to the controller. A clear select bit routes the hardware source to the controller unchanged. The selection for each line is computed from its own bits only, and the output vector is combinational.

Top module: `irq_inject_apb`

## Requirements
- R1: The block serves 160 lines through five 32-bit level registers at byte addresses 0x00, 0x04, 0x08, 0x0C, 0x10 and five 32-bit select registers at 0x20, 0x24, 0x28, 0x2C, 0x30. Bit i of register n of either bank belongs to line 32n+i.
- R2: When the select bit of a line is 1, the line's output equals the line's bit in the level register.
- R3: When the select bit of a line is 0, the line's output equals the line's hardware input.
- R4: Each line's output depends only on that line's own select bit, level bit and hardware input. Lines with different settings in the same register do not affect each other.
- R5: A read of a mapped address returns the value last written to that register, not the muxed output.
- R6: Every access completes in its first access-phase cycle. pready is high whenever psel and penable are high, and pslverr is low for mapped addresses.
- R7: An access to any other address, including one with paddr[1:0] not equal to zero, is unmapped. It reads as zero, its write changes no register, and it raises pslverr in the access phase.
- R8: Reset clears all registers, so after reset every output equals its hardware input and every mapped read returns zero.
- R9: A register write changes the output only after the clock edge that ends the access phase. A change on the hardware input appears on the output in the same cycle, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pclk | input | 1 | APB clock |
| presetn | input | 1 | Active-low reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access-phase strobe |
| pwrite | input | 1 | 1 for write, 0 for read |
| paddr | input | 8 | Byte address |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data |
| pready | output | 1 | Transfer complete |
| pslverr | output | 1 | Unmapped-address error |
| hw_irq | input | 160 | Hardware interrupt sources |
| irq_out | output | 160 | Levels presented to the interrupt controller |

## Verification
The hardware vector is driven with all zeros, all ones, alternating patterns and pseudo-random words. Each pattern is combined with level and select registers of opposite polarity, so a line that wrongly takes its hardware input is always distinguished from one that takes its software level. A single select bit set in register 3 checks the line-to-bit mapping. Half-set select words show that lines sharing a register stay independent. The output is sampled inside the access phase of a select write and again after its closing edge, which separates the intended one-edge latency from a combinational path through pwdata. Reads and writes at gap, unaligned and out-of-range addresses show that they store nothing and raise the error flag.

// File: rtl/irq_inject_apb.sv
module irq_inject_apb #(
  parameter int NUM_REGS  = 5,
  parameter int REG_W     = 32,
  parameter int ADDR_W    = 8,
  parameter int MASK_BASE = 32,
  localparam int LINES    = NUM_REGS * REG_W
) (
  input  logic              pclk,
  input  logic              presetn,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [REG_W-1:0]  pwdata,
  output logic [REG_W-1:0]  prdata,
  output logic              pready,
  output logic              pslverr,
  input  logic [LINES-1:0]  hw_irq,
  output logic [LINES-1:0]  irq_out
);
  localparam int AW = ADDR_W - 2;
  localparam logic [AW-1:0] SEL_WORD = AW'(MASK_BASE / 4);

  logic [AW-1:0]    word;
  logic             aligned, lvl_hit, sel_hit, access, wr_en;
  logic [REG_W-1:0] lvl_q [NUM_REGS];
  logic [REG_W-1:0] sel_q [NUM_REGS];
  logic [REG_W-1:0] rd_mux;

  assign word    = paddr[ADDR_W-1:2];
  assign aligned = (paddr[1:0] == 2'b00);
  assign lvl_hit = aligned && (word < AW'(NUM_REGS));
  assign sel_hit = aligned && (word >= SEL_WORD) && (word < SEL_WORD + AW'(NUM_REGS));
  assign access  = psel && penable;
  assign wr_en   = access && pwrite;

  for (genvar n = 0; n < NUM_REGS; n++) begin : g_reg
    always_ff @(posedge pclk or negedge presetn) begin
      if (!presetn) begin
        lvl_q[n] <= '0;
        sel_q[n] <= '0;
      end else if (wr_en && aligned) begin
        if (word == AW'(n))            lvl_q[n] <= pwdata;
        if (word == SEL_WORD + AW'(n)) sel_q[n] <= pwdata;
      end
    end

    assign irq_out[n*REG_W +: REG_W] =
      (sel_q[n] & lvl_q[n]) | (~sel_q[n] & hw_irq[n*REG_W +: REG_W]);
  end

  always_comb begin
    rd_mux = '0;
    for (int n = 0; n < NUM_REGS; n++) begin
      if (lvl_hit && word == AW'(n))            rd_mux = lvl_q[n];
      if (sel_hit && word == SEL_WORD + AW'(n)) rd_mux = sel_q[n];
    end
  end

  assign prdata  = rd_mux;
  assign pready  = 1'b1;
  assign pslverr = access && !(lvl_hit || sel_hit);
endmodule

// File: rtl/irq_inject_apb_chk.sv
module irq_inject_apb_chk #(
  parameter int NUM_REGS  = 5,
  parameter int REG_W     = 32,
  parameter int ADDR_W    = 8,
  parameter int MASK_BASE = 32,
  localparam int LINES    = NUM_REGS * REG_W
) (
  input logic              pclk,
  input logic              presetn,
  input logic              psel,
  input logic              penable,
  input logic              pwrite,
  input logic [ADDR_W-1:0] paddr,
  input logic [REG_W-1:0]  pwdata,
  input logic [REG_W-1:0]  prdata,
  input logic              pready,
  input logic              pslverr,
  input logic [LINES-1:0]  hw_irq,
  input logic [LINES-1:0]  irq_out
);
  logic              acc, mapped, last_vld;
  logic [ADDR_W-1:0] last_addr;
  logic [REG_W-1:0]  last_data;
  int                a;

  assign acc    = psel && penable;
  assign a      = int'(paddr);
  assign mapped = (paddr[1:0] == 2'b00) &&
                  ((a < 4*NUM_REGS) || (a >= MASK_BASE && a < MASK_BASE + 4*NUM_REGS));

  always_ff @(posedge pclk or negedge presetn) begin
    if (!presetn) begin
      last_vld  <= 1'b0;
      last_addr <= '0;
      last_data <= '0;
    end else if (acc && pwrite && mapped) begin
      last_vld  <= 1'b1;
      last_addr <= paddr;
      last_data <= pwdata;
    end
  end

  AST_READY_IN_ACCESS: assert property (@(posedge pclk) disable iff (!presetn)
    acc |-> pready && (pslverr == !mapped)); // R6

  AST_UNMAPPED_ZERO: assert property (@(posedge pclk) disable iff (!presetn)
    (acc && !pwrite && !mapped) |-> (prdata == '0)); // R7

  AST_READBACK: assert property (@(posedge pclk) disable iff (!presetn)
    (acc && !pwrite && last_vld && paddr == last_addr) |-> (prdata == last_data)); // R5

  AST_PASS_AFTER_RESET: assert property (@(posedge pclk) disable iff (!presetn)
    $past(!presetn) |-> (irq_out == hw_irq)); // R8

  AST_HOLD_WITHOUT_WRITE: assert property (@(posedge pclk) disable iff (!presetn)
    ($past(!(acc && pwrite)) && $stable(hw_irq)) |-> $stable(irq_out)); // R9
endmodule

bind irq_inject_apb irq_inject_apb_chk #(
  .NUM_REGS(NUM_REGS), .REG_W(REG_W), .ADDR_W(ADDR_W), .MASK_BASE(MASK_BASE)
) u_chk (
  .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable), .pwrite(pwrite),
  .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready), .pslverr(pslverr),
  .hw_irq(hw_irq), .irq_out(irq_out)
);

// File: tb/test_irq_inject_apb.sv
module test_irq_inject_apb;
  localparam int NR = 5;
  localparam int W  = 32;
  localparam int L  = NR * W;

  logic          pclk = 0, presetn = 0;
  logic          psel = 0, penable = 0, pwrite = 0;
  logic [7:0]    paddr = '0;
  logic [W-1:0]  pwdata = '0;
  logic [W-1:0]  prdata;
  logic          pready, pslverr;
  logic [L-1:0]  hw_irq = '0;
  logic [L-1:0]  irq_out;

  irq_inject_apb i_irq_inject_apb (.*);

  always #5 pclk = ~pclk;

  typedef struct {
    bit          is_rd;
    logic [W-1:0] rd;
    bit          err;
    string       req;
  } item_t;

  item_t        sb[$];
  int           checks = 0, errors = 0;
  logic [W-1:0] m_lvl [NR];
  logic [W-1:0] m_sel [NR];

  function automatic bit is_mapped(logic [7:0] ad);
    return ad[1:0] == 0 && (ad < 8'h14 || (ad >= 8'h20 && ad < 8'h34));
  endfunction

  function automatic logic [W-1:0] model_rd(logic [7:0] ad);
    if (!is_mapped(ad)) return '0;
    return ad < 8'h20 ? m_lvl[ad >> 2] : m_sel[(ad - 8'h20) >> 2];
  endfunction

  function automatic logic [L-1:0] model_out();
    logic [L-1:0] o;
    for (int n = 0; n < NR; n++)
      for (int i = 0; i < W; i++)
        o[n*W+i] = m_sel[n][i] ? m_lvl[n][i] : hw_irq[n*W+i];
    return o;
  endfunction

  task automatic check(string req, logic [L-1:0] act, logic [L-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  // monitor: pops one expected item per access phase
  initial forever begin
    @(negedge pclk);
    if (psel && penable) begin
      item_t it;
      if (sb.size() == 0) begin
        check("R6", 1, 0);
      end else begin
        it = sb.pop_front();
        check("R6", L'(pready), L'(1'b1));
        check(it.req, L'(pslverr), L'(it.err));
        if (it.is_rd) check(it.req, L'(prdata), L'(it.rd));
      end
    end
  end

  task automatic apb(bit wr, logic [7:0] ad, logic [W-1:0] d, string req, bit mid_chk = 0);
    item_t it;
    logic [L-1:0] old;
    it.is_rd = !wr; it.rd = model_rd(ad); it.err = !is_mapped(ad); it.req = req;
    sb.push_back(it);
    @(posedge pclk); #1;
    psel = 1; pwrite = wr; paddr = ad; pwdata = d;
    @(posedge pclk); #1;
    penable = 1;
    old = model_out();
    if (mid_chk) begin
      @(negedge pclk);
      check("R9", irq_out, old);
    end
    @(posedge pclk); #1;
    psel = 0; penable = 0;
    if (wr && is_mapped(ad)) begin
      if (ad < 8'h20) m_lvl[ad >> 2] = d;
      else m_sel[(ad - 8'h20) >> 2] = d;
    end
  endtask

  task automatic out_chk(string req);
    @(negedge pclk);
    check(req, irq_out, model_out());
  endtask

  task automatic read_all(string req);
    for (int n = 0; n < NR; n++) begin
      apb(0, 8'(4*n), '0, req);
      apb(0, 8'(8'h20 + 4*n), '0, req);
    end
  endtask

  initial begin
    for (int n = 0; n < NR; n++) begin m_lvl[n] = '0; m_sel[n] = '0; end
    hw_irq = {5{32'hA5C3_0F96}};
    repeat (3) @(posedge pclk);
    #1 presetn = 1;

    // R8: reset state
    out_chk("R8");
    read_all("R8");

    // R3: levels written, selects clear -> hardware passes
    for (int n = 0; n < NR; n++) apb(1, 8'(4*n), ~hw_irq[n*W +: W], "R3");
    out_chk("R3");
    hw_irq = '1;  out_chk("R3");
    hw_irq = '0;  out_chk("R3");
    read_all("R5");

    // R1: one select bit in register 3 maps to line 101
    for (int n = 0; n < NR; n++) apb(1, 8'(4*n), '0, "R1");
    hw_irq = '0;
    apb(1, 8'h0C, 32'h0000_0020, "R1");
    apb(1, 8'h2C, 32'h0000_0020, "R1");
    out_chk("R1");
    check("R1", L'(irq_out[101]), L'(1'b1));
    check("R1", L'(irq_out[100]) | L'(irq_out[102]) | L'(irq_out[5]), '0);

    // R2/R4: all selects set, opposite polarity, then half selects
    for (int n = 0; n < NR; n++) begin
      apb(1, 8'(4*n), 32'h0F0F_3C3C ^ W'(n), "R2");
      apb(1, 8'(8'h20 + 4*n), '1, "R2");
    end
    hw_irq = {5{32'hF0F0_C3C3}};
    out_chk("R2");
    hw_irq = {$urandom, $urandom, $urandom, $urandom, $urandom};
    out_chk("R2");
    for (int n = 0; n < NR; n++) apb(1, 8'(8'h20 + 4*n), 32'h5555_AAAA, "R4");
    hw_irq = '1; out_chk("R4");
    hw_irq = {5{32'h3333_CCCC}}; out_chk("R4");
    read_all("R5");

    // R9: write latency and combinational hardware path
    apb(1, 8'h20, 32'h0000_FFFF, "R9", 1);
    #1 check("R9", irq_out, model_out());
    hw_irq = ~hw_irq;
    #1 check("R9", irq_out, model_out());

    // R7: unmapped and unaligned accesses
    apb(1, 8'h14, '1, "R7");
    apb(1, 8'h1C, '1, "R7");
    apb(1, 8'h34, '1, "R7");
    apb(1, 8'hFC, '1, "R7");
    apb(1, 8'h22, '1, "R7");
    apb(0, 8'h14, '0, "R7");
    apb(0, 8'h22, '0, "R7");
    apb(0, 8'hFC, '0, "R7");
    out_chk("R7");
    read_all("R7");

    repeat (3) @(posedge pclk);
    check("R6", L'(sb.size()), '0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge pclk);
    checks++; errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule